// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 32-bit operands and an incoming carry. It returns a 32-bit sum and an outgoing carry. It is purely combinational: it has no clock, no state and no handshake. The operand bits are split into six segments whose widths grow toward the most significant end, except for a short final segment. Every segment above the bottom one works out its partial sum twice, once assuming an incoming carry of 0 and once assuming 1. The real carry leaving the segment below then steers a multiplexer that picks both the partial sum and that segment's own outgoing carry.

In a unit-delay model a ripple segment of width w settles after w units and a multiplexer adds one unit. The widths are therefore chosen so that each steering carry turns up at about the moment its segment's two candidate results settle. The widths run 4, 5, 6, 7, 8 and 2 bits, starting from bit 0. The bottom segment normally uses a single ripple adder fed straight from the carry input. A parameter can swap in the duplicated form instead, and the results are the same.

The segment widths are parameters. A wider or narrower adder can be built by changing the width list, provided the widths add up to the operand width.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `carry_i`) modulo 2^32 for every input combination.
- R2: `carry_o` equals bit 32 of the unbounded sum `a_i` + `b_i` + `carry_i`.
- R3: The segment boundaries sit between bits 3/4, 8/9, 14/15, 21/22 and 29/30. A carry produced in any segment reaches every higher sum bit through all of these boundaries, including a carry that runs from `carry_i` up through bit 31.
- R4: Bits 3 down to 0 of `sum_o` depend only on bits 3 down to 0 of both operands and on `carry_i`.
- R5: When `a_i` is the bitwise inverse of `b_i` (every bit propagates), `carry_o` equals `carry_i`. `sum_o` is then all ones for `carry_i` = 0 and all zeros for `carry_i` = 1.
- R6: Changing operand bits 31 down to 9 leaves `sum_o` bits 8 down to 0 unchanged.
- R7: With both operands zero, `sum_o` equals `carry_i` and `carry_o` is 0.
- R8: With both operands all ones and `carry_i` = 1, `sum_o` is all ones and `carry_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Incoming carry at bit 0 |
| sum_o | output | 32 | Sum modulo 2^32 |
| carry_o | output | 1 | Outgoing carry from bit 31 |

## Verification
Uniform random operands almost never launch a carry that crosses several segments. The selected-carry paths that matter most are therefore the ones least likely to be hit by chance. The stimulus builds them on purpose. It uses operands whose bits all propagate, with the carry input set or clear, so that one carry runs from bit 0 through every multiplexer. It also places generate-then-propagate patterns that start just below each boundary and stop just above it. Separate operand pairs differ only in the upper bits or only in the lower nibble, to show that carries never flow downward.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int MAX_SEG = 16;
  typedef int unsigned seg_list_t [MAX_SEG];

  localparam seg_list_t DEF_SEG_W = '{0: 4, 1: 5, 2: 6, 3: 7, 4: 8, 5: 2, default: 0};

  // lowest bit index of segment k
  function automatic int unsigned seg_lo(seg_list_t w, int k);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < MAX_SEG; i++)
      if (i < k) acc += w[i];
    return acc;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic c;
  always_comb begin
    c = cin;
    s = '0;
    for (int i = 0; i < W; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    cout = c;
  end
endmodule

// File: rtl/csa_select_seg.sv
module csa_select_seg #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W-1:0] s_lo, s_hi;
  logic         c_lo, c_hi;

  csa_ripple #(.W(W)) u_zero (.x(x), .y(y), .cin(1'b0), .s(s_lo), .cout(c_lo));
  csa_ripple #(.W(W)) u_one  (.x(x), .y(y), .cin(1'b1), .s(s_hi), .cout(c_hi));

  always_comb begin
    if (sel) begin
      s    = s_hi;
      cout = c_hi;
    end else begin
      s    = s_lo;
      cout = c_lo;
    end
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csa_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter int        NUM_SEG  = 6,
  parameter seg_list_t SEG_W    = DEF_SEG_W,
  parameter bit        BASE_DUP = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int TOP = NUM_SEG - 1;

  // selected carry leaving each segment
  logic [NUM_SEG-1:0] carry_bus;

  for (genvar k = 0; k < NUM_SEG; k++) begin : seg_g
    localparam int LO = int'(seg_lo(SEG_W, k));
    localparam int W  = int'(SEG_W[k]);
    logic         cin_sel;
    logic         cout_sel;
    logic [W-1:0] s;

    if (k == 0) begin : base_g
      assign cin_sel = carry_i;
      if (BASE_DUP) begin : dup_g
        csa_select_seg #(.W(W)) u_add (
          .x(a_i[LO +: W]), .y(b_i[LO +: W]), .sel(cin_sel), .s(s), .cout(cout_sel));
      end else begin : single_g
        csa_ripple #(.W(W)) u_add (
          .x(a_i[LO +: W]), .y(b_i[LO +: W]), .cin(cin_sel), .s(s), .cout(cout_sel));
      end
    end else begin : upper_g
      assign cin_sel = seg_g[k-1].cout_sel;
      csa_select_seg #(.W(W)) u_add (
        .x(a_i[LO +: W]), .y(b_i[LO +: W]), .sel(cin_sel), .s(s), .cout(cout_sel));
    end

    assign sum_o[LO +: W] = s;
    assign carry_bus[k]   = cout_sel;
  end

  assign carry_o = carry_bus[TOP];
endmodule

// File: rtl/csa_checker.sv
module csa_checker
  import csa_pkg::*;
#(
  parameter int        WIDTH   = 32,
  parameter int        NUM_SEG = 6,
  parameter seg_list_t SEG_W   = DEF_SEG_W
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               carry_i,
  input logic [WIDTH-1:0]   sum_o,
  input logic               carry_o,
  input logic [NUM_SEG-1:0] carry_bus
);
  logic [WIDTH:0] full;
  logic [WIDTH:0] mask;
  logic [WIDTH:0] part;
  int unsigned    hi;

  always_comb begin
    full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
    // R1
    sum_value_chk: assert (sum_o == full[WIDTH-1:0]);
    // R2
    msb_gen_chk: assert (!(a_i[WIDTH-1] && b_i[WIDTH-1]) || carry_o);
    // R5
    propagate_chk: assert ((a_i != ~b_i) || (carry_o == carry_i));
    // R7
    zero_ops_chk: assert (!(a_i == '0 && b_i == '0) ||
                          (sum_o == {{(WIDTH-1){1'b0}}, carry_i} && !carry_o));
    for (int k = 0; k < NUM_SEG; k++) begin
      hi   = seg_lo(SEG_W, k) + SEG_W[k];
      mask = ({{WIDTH{1'b0}}, 1'b1} << hi) - 1'b1;
      part = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask) + {{WIDTH{1'b0}}, carry_i};
      // R3
      boundary_carry_chk: assert (carry_bus[k] == part[hi]);
    end
  end
endmodule

bind sqrt_csel_adder csa_checker #(.WIDTH(WIDTH), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .sum_o(sum_o), .carry_o(carry_o),
  .carry_bus(carry_bus));

// File: tb/sim_sqrt_csel_adder.sv
module sim_sqrt_csel_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic        ci = 1'b0;
  logic [31:0] sum;
  logic        co;
  int          n_run = 0, n_fail = 0;
  logic [32:0] exp_q[$];

  always #2.5 clk = ~clk;

  sqrt_csel_adder u0 (.a_i(a), .b_i(b), .carry_i(ci), .sum_o(sum), .carry_o(co));

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on rising edge, compare against reference on falling edge
  task automatic apply(string req, logic [31:0] x, logic [31:0] y, logic c);
    longint unsigned r;
    @(posedge clk);
    a = x; b = y; ci = c;
    r = longint'(x) + longint'(y) + longint'(c);
    exp_q.push_back(r[32:0]);
    @(negedge clk);
    check(req, {co, sum}, exp_q.pop_front());
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lo_ref;
    logic [3:0]  nib_ref;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset state", {co, sum}, 33'd0);
    apply("R7 zero cin0", 32'h0, 32'h0, 1'b0);
    apply("R7 zero cin1", 32'h0, 32'h0, 1'b1);
    check("R7 sum=carry_i", {co, sum}, 33'd1);
    apply("R8 ones+ones+1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check("R8 exact", {co, sum}, {1'b1, 32'hFFFF_FFFF});
    apply("R5 propagate cin0", 32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0);
    check("R5 all ones", {co, sum}, {1'b0, 32'hFFFF_FFFF});
    apply("R5 propagate cin1", 32'hFFFF_FFFF, 32'h0, 1'b1);
    check("R5 full ripple", {co, sum}, {1'b1, 32'h0});
    apply("R2 msb carry", 32'h8000_0000, 32'h8000_0000, 1'b0);
    check("R2 carry_o", {32'h0, co}, 33'd1);
    // R3: carry launched just below each boundary crosses it
    foreach (csa_pkg::DEF_SEG_W[k]) begin
      if (k < 5) begin
        int unsigned bnd = csa_pkg::seg_lo(csa_pkg::DEF_SEG_W, k + 1);
        apply("R3 boundary cross", 32'h1 << (bnd - 1), (32'h1 << (bnd - 1)) | (32'h1 << bnd), 1'b0);
        check("R3 bit above boundary", {1'b0, sum}, {1'b0, 32'h1 << (bnd + 1)});
        apply("R3 cin to boundary", (32'h1 << bnd) - 1, 32'h0, 1'b1);
        check("R3 cin chain", {1'b0, sum}, {1'b0, 32'h1 << bnd});
      end
    end
    // R6: upper bits never disturb lower nine sum bits
    for (int i = 0; i < 20; i++) begin
      logic [31:0] x = $urandom, y = $urandom;
      logic        c = 1'($urandom);
      apply("R6 base", x, y, c);
      lo_ref = sum;
      apply("R6 upper change", x ^ ($urandom << 9), y ^ ($urandom << 9), c);
      check("R6 low bits", {24'h0, sum[8:0]}, {24'h0, lo_ref[8:0]});
    end
    // R4: low nibble depends only on low nibbles and carry_i
    for (int i = 0; i < 20; i++) begin
      logic [31:0] x = $urandom, y = $urandom;
      logic        c = 1'($urandom);
      nib_ref = x[3:0] + y[3:0] + {3'b0, c};
      apply("R4 nibble", x, y, c);
      check("R4 low nibble", {29'h0, sum[3:0]}, {29'h0, nib_ref});
    end
    // R1/R2: random and sparse operands against the reference
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x = $urandom, y = $urandom;
      if (i % 3 == 1) y = ~x ^ (32'h1 << (i % 32));
      if (i % 3 == 2) x = x | 32'hFFFF_0000;
      apply("R1 R2 random", x, y, 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule